// File: doc/BRIEF.md
# Privilege Level Exception Entry Controller

This controller moves a processor core between four privilege levels: 0 user, 1 kernel, 2 hypervisor, 3 secure monitor. It handles taking an exception and executing a return-from-exception. An exception request carries a kind, the current PC, the current processor-state word and a syndrome value. From these the controller works out the level that takes the exception. It saves the old state, the return address and a reason code into that level's banked registers. It then produces the handler PC from the level's vector base plus an offset.

For every level the block keeps a saved-state word, a link address, a syndrome word, a vector base and a stack pointer. A simple configuration write port loads the vector base, stack pointer, link address or saved-state word of any level, which is how setup code reaches a lower level through a return. The state word the block keeps has a fixed layout: bit 0 selects the stack (1 = the level's own pointer, 0 = the level-0 pointer), bits 3:2 hold the level, bit 1 and bits 7:4 are flags carried from the request.

Top module: `plvl_exc_ctrl`

## Requirements
- R1: After reset the level is 3 and `stateOut` is 8'h0D, so the level's own stack is selected. `pcValid` is 0, and every banked register reads as zero.
- R2: The kind codes are 0 supervisor call, 1 hypervisor call, 2 monitor call, 3 synchronous fault, 4 IRQ, 5 FIQ and 6 system error. A supervisor call goes to the larger of level 1 and the current level. A hypervisor call from level 1 or above goes to the larger of level 2 and the current level. A monitor call from level 1 or above goes to level 3.
- R3: A hypervisor or monitor call issued at level 0 is taken to level 1 as an undefined instruction. Its syndrome has class 6'h00 and a zero detail field.
- R4: For an IRQ the routed level is 3 if `irqToMon` is set, else 2 if `irqToHyp` is set, else 1. An FIQ is routed the same way with `fiqToMon` and `fiqToHyp`. The target is the larger of the routed level and the current level. A synchronous fault and a system error go to the larger of level 1 and the current level. Taking an exception never lowers the level.
- R5: On entry the target's saved-state word gets {curState[7:4], old level, curState[1], old stack select}. The new `stateOut` is {curState[7:4], target, curState[1], 1}. A return makes `stateOut` equal to the current level's saved-state word.
- R6: On entry the target's link register gets `curPc`+4. A return loads `newPc` from the current level's link register. `pcValid` is high for exactly the one cycle after an accepted entry or return.
- R7: On entry the target's syndrome becomes {class, syndIn}. The class is 6'h15 supervisor, 6'h16 hypervisor, 6'h17 monitor, 6'h20 fault, 6'h3A IRQ, 6'h3B FIQ and 6'h2F system error. `syndOut` shows the current level's syndrome.
- R8: The handler PC is the target's vector base plus a group offset plus a kind offset. The group offset is 0x400 when the target is above the current level, 0x200 for the same level with its own stack selected, and 0x000 for the same level on the level-0 stack. The kind offset is 0x000 for synchronous kinds, 0x080 for IRQ, 0x100 for FIQ and 0x180 for system error.
- R9: `activeSp` is the current level's stack pointer when bit 0 of the state word is 1, and the level-0 stack pointer otherwise.
- R10: A return requested at level 0 has no effect: there is no PC load and the level and state are unchanged. When an exception and a return arrive in the same cycle, the exception is taken.
- R11: A configuration write with `cfgSel` 0 vector base, 1 stack pointer, 2 link, 3 saved state updates the register of level `cfgLvl` by the next cycle. It leaves the current level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Take an exception this cycle |
| excKind | input | 3 | Exception kind code |
| retReq | input | 1 | Return from exception |
| curPc | input | AW | PC of the excepting instruction |
| curState | input | 8 | Flag bits of the current state word |
| syndIn | input | YW | Detail field for the syndrome |
| irqToHyp | input | 1 | Route IRQ to level 2 |
| irqToMon | input | 1 | Route IRQ to level 3 |
| fiqToHyp | input | 1 | Route FIQ to level 2 |
| fiqToMon | input | 1 | Route FIQ to level 3 |
| cfgWe | input | 1 | Configuration write strobe |
| cfgLvl | input | 2 | Level whose register is written |
| cfgSel | input | 2 | Register selector |
| cfgData | input | AW | Write data |
| pcValid | output | 1 | newPc must be loaded |
| newPc | output | AW | Handler or return PC |
| curLevel | output | 2 | Current privilege level |
| stateOut | output | 8 | Current state word |
| activeSp | output | AW | Selected stack pointer |
| syndOut | output | 6+YW | Current level's syndrome |

## Verification
The vector-offset property takes for granted that every vector base has its low 11 bits clear, so an offset can be read from the bottom of `newPc`. The bench only programs bases that are multiples of 0x10000. The level properties assume `excKind` never carries the unused code 7, and the stimulus uses only the seven defined kinds. Returns are driven only after the saved-state word of the current level names a level no higher than the current one, so a return never raises the level.

// File: rtl/plvl_pkg.sv
package plvl_pkg;
  localparam int LVLS  = 4;
  localparam int LW    = 2;
  localparam int CLSW  = 6;
  localparam int STW   = 8;
  localparam int OFFW  = 12;
  localparam logic [STW-1:0] RESET_STATE = 8'h0D;

  typedef enum logic [2:0] {
    K_SVC   = 3'd0,
    K_HVC   = 3'd1,
    K_SMC   = 3'd2,
    K_FAULT = 3'd3,
    K_IRQ   = 3'd4,
    K_FIQ   = 3'd5,
    K_SERR  = 3'd6
  } kind_e;

  localparam logic [CLSW-1:0] CLS_UNDEF = 6'h00;
  localparam logic [CLSW-1:0] CLS_SVC   = 6'h15;
  localparam logic [CLSW-1:0] CLS_HVC   = 6'h16;
  localparam logic [CLSW-1:0] CLS_SMC   = 6'h17;
  localparam logic [CLSW-1:0] CLS_FAULT = 6'h20;
  localparam logic [CLSW-1:0] CLS_SERR  = 6'h2F;
  localparam logic [CLSW-1:0] CLS_IRQ   = 6'h3A;
  localparam logic [CLSW-1:0] CLS_FIQ   = 6'h3B;

  typedef struct packed {
    logic            enter;
    logic            leave;
    logic [LW-1:0]   tgt;
    logic [CLSW-1:0] cls;
    logic            keepIss;
    logic [OFFW-1:0] vecOff;
  } strobe_t;
endpackage

// File: rtl/plvl_ctrl.sv
module plvl_ctrl
  import plvl_pkg::*;
(
  input  logic          excReq,
  input  logic [2:0]    excKind,
  input  logic          retReq,
  input  logic [LW-1:0] curLvl,
  input  logic          spSel,
  input  logic          irqToHyp,
  input  logic          irqToMon,
  input  logic          fiqToHyp,
  input  logic          fiqToMon,
  output strobe_t       stb
);
  function automatic logic [LW-1:0] maxLvl(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [LW-1:0]   tgt;
  logic [CLSW-1:0] cls;
  logic            keepIss;
  logic [OFFW-1:0] kindOff;
  logic [OFFW-1:0] grpOff;
  logic [LW-1:0]   irqRoute;
  logic [LW-1:0]   fiqRoute;

  always_comb begin
    irqRoute = irqToMon ? 2'd3 : (irqToHyp ? 2'd2 : 2'd1);
    fiqRoute = fiqToMon ? 2'd3 : (fiqToHyp ? 2'd2 : 2'd1);
    tgt      = maxLvl(2'd1, curLvl);
    cls      = CLS_FAULT;
    keepIss  = 1'b1;
    kindOff  = 12'h000;
    case (kind_e'(excKind))
      K_SVC: cls = CLS_SVC;
      K_HVC: begin
        if (curLvl == 2'd0) begin
          cls = CLS_UNDEF; keepIss = 1'b0;
        end else begin
          tgt = maxLvl(2'd2, curLvl); cls = CLS_HVC;
        end
      end
      K_SMC: begin
        if (curLvl == 2'd0) begin
          cls = CLS_UNDEF; keepIss = 1'b0;
        end else begin
          tgt = 2'd3; cls = CLS_SMC;
        end
      end
      K_IRQ: begin
        tgt = maxLvl(irqRoute, curLvl); cls = CLS_IRQ; kindOff = 12'h080;
      end
      K_FIQ: begin
        tgt = maxLvl(fiqRoute, curLvl); cls = CLS_FIQ; kindOff = 12'h100;
      end
      K_SERR: begin
        cls = CLS_SERR; kindOff = 12'h180;
      end
      default: cls = CLS_FAULT;
    endcase
    if (tgt > curLvl)  grpOff = 12'h400;
    else if (spSel)    grpOff = 12'h200;
    else               grpOff = 12'h000;
  end

  assign stb.enter   = excReq;
  assign stb.leave   = retReq && !excReq && (curLvl != 2'd0);
  assign stb.tgt     = tgt;
  assign stb.cls     = cls;
  assign stb.keepIss = keepIss;
  assign stb.vecOff  = grpOff + kindOff;
endmodule

// File: rtl/plvl_dpath.sv
module plvl_dpath
  import plvl_pkg::*;
#(
  parameter int AW = 32,
  parameter int YW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [AW-1:0]    curPc,
  input  logic [STW-1:0]   curState,
  input  logic [YW-1:0]    syndIn,
  input  logic             cfgWe,
  input  logic [LW-1:0]    cfgLvl,
  input  logic [1:0]       cfgSel,
  input  logic [AW-1:0]    cfgData,
  output logic             pcValid,
  output logic [AW-1:0]    newPc,
  output logic [LW-1:0]    curLvl,
  output logic             spSel,
  output logic [STW-1:0]   stateOut,
  output logic [AW-1:0]    activeSp,
  output logic [CLSW+YW-1:0] syndOut
);
  localparam int SYW = CLSW + YW;

  logic [STW-1:0] stateQ;
  logic [AW-1:0]  pcQ;
  logic           pcValidQ;

  logic [AW-1:0]  vbarArr  [LVLS];
  logic [AW-1:0]  spArr    [LVLS];
  logic [AW-1:0]  linkArr  [LVLS];
  logic [STW-1:0] savedArr [LVLS];
  logic [SYW-1:0] syndArr  [LVLS];

  logic [STW-1:0] savedWord;
  logic [SYW-1:0] syndWord;
  logic [AW-1:0]  retAddr;

  assign savedWord = {curState[7:4], stateQ[3:2], curState[1], stateQ[0]};
  assign syndWord  = {stb.cls, (stb.keepIss ? syndIn : {YW{1'b0}})};
  assign retAddr   = curPc + AW'(4);

  for (genvar g = 0; g < LVLS; g++) begin : gBank
    logic [AW-1:0]  vbar;
    logic [AW-1:0]  sp;
    logic [AW-1:0]  link;
    logic [STW-1:0] saved;
    logic [SYW-1:0] synd;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vbar <= '0; sp <= '0; link <= '0; saved <= '0; synd <= '0;
      end else begin
        if (stb.enter && stb.tgt == LW'(g)) begin
          link  <= retAddr;
          saved <= savedWord;
          synd  <= syndWord;
        end
        if (cfgWe && cfgLvl == LW'(g)) begin
          case (cfgSel)
            2'd0: vbar  <= cfgData;
            2'd1: sp    <= cfgData;
            2'd2: link  <= cfgData;
            default: saved <= cfgData[STW-1:0];
          endcase
        end
      end
    end

    assign vbarArr[g]  = vbar;
    assign spArr[g]    = sp;
    assign linkArr[g]  = link;
    assign savedArr[g] = saved;
    assign syndArr[g]  = synd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= RESET_STATE;
      pcQ      <= '0;
      pcValidQ <= 1'b0;
    end else begin
      pcValidQ <= stb.enter || stb.leave;
      if (stb.enter) begin
        pcQ    <= vbarArr[stb.tgt] + AW'(stb.vecOff);
        stateQ <= {curState[7:4], stb.tgt, curState[1], 1'b1};
      end else if (stb.leave) begin
        pcQ    <= linkArr[stateQ[3:2]];
        stateQ <= savedArr[stateQ[3:2]];
      end
    end
  end

  assign curLvl   = stateQ[3:2];
  assign spSel    = stateQ[0];
  assign stateOut = stateQ;
  assign newPc    = pcQ;
  assign pcValid  = pcValidQ;
  assign activeSp = spArr[stateQ[0] ? stateQ[3:2] : 2'd0];
  assign syndOut  = syndArr[stateQ[3:2]];
endmodule

// File: rtl/plvl_exc_ctrl.sv
module plvl_exc_ctrl
  import plvl_pkg::*;
#(
  parameter int AW = 32,
  parameter int YW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           excReq,
  input  logic [2:0]     excKind,
  input  logic           retReq,
  input  logic [AW-1:0]  curPc,
  input  logic [7:0]     curState,
  input  logic [YW-1:0]  syndIn,
  input  logic           irqToHyp,
  input  logic           irqToMon,
  input  logic           fiqToHyp,
  input  logic           fiqToMon,
  input  logic           cfgWe,
  input  logic [1:0]     cfgLvl,
  input  logic [1:0]     cfgSel,
  input  logic [AW-1:0]  cfgData,
  output logic           pcValid,
  output logic [AW-1:0]  newPc,
  output logic [1:0]     curLevel,
  output logic [7:0]     stateOut,
  output logic [AW-1:0]  activeSp,
  output logic [5+YW:0]  syndOut
);
  strobe_t       stb;
  logic [LW-1:0] lvl;
  logic          spSel;

  plvl_ctrl uCtrl (
    .excReq(excReq), .excKind(excKind), .retReq(retReq),
    .curLvl(lvl), .spSel(spSel),
    .irqToHyp(irqToHyp), .irqToMon(irqToMon),
    .fiqToHyp(fiqToHyp), .fiqToMon(fiqToMon),
    .stb(stb)
  );

  plvl_dpath #(.AW(AW), .YW(YW)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .curPc(curPc), .curState(curState), .syndIn(syndIn),
    .cfgWe(cfgWe), .cfgLvl(cfgLvl), .cfgSel(cfgSel), .cfgData(cfgData),
    .pcValid(pcValid), .newPc(newPc), .curLvl(lvl), .spSel(spSel),
    .stateOut(stateOut), .activeSp(activeSp), .syndOut(syndOut)
  );

  assign curLevel = lvl;
endmodule

// File: rtl/plvl_chk.sv
module plvl_chk #(
  parameter int AW = 32,
  parameter int YW = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           excReq,
  input logic [2:0]     excKind,
  input logic           retReq,
  input logic [AW-1:0]  curPc,
  input logic [7:0]     curState,
  input logic [YW-1:0]  syndIn,
  input logic           irqToHyp,
  input logic           irqToMon,
  input logic           fiqToHyp,
  input logic           fiqToMon,
  input logic           cfgWe,
  input logic [1:0]     cfgLvl,
  input logic [1:0]     cfgSel,
  input logic [AW-1:0]  cfgData,
  input logic           pcValid,
  input logic [AW-1:0]  newPc,
  input logic [1:0]     curLevel,
  input logic [7:0]     stateOut,
  input logic [AW-1:0]  activeSp,
  input logic [5+YW:0]  syndOut
);
  assert_entry_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> pcValid);

  assert_low_ret_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !excReq && curLevel == 2'd0) |=> (!pcValid && curLevel == 2'd0));

  assert_low_call_undef_R3: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && (excKind == 3'd1 || excKind == 3'd2) && curLevel == 2'd0)
      |=> (curLevel == 2'd1 && syndOut == '0));

  assert_monitor_call_R2: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excKind == 3'd2 && curLevel != 2'd0) |=> (curLevel == 2'd3));

  assert_lower_vector_R8: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excKind == 3'd0 && curLevel == 2'd0) |=> (newPc[10:0] == 11'h400));

  assert_never_lower_R4: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (curLevel >= $past(curLevel) && curLevel != 2'd0));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!excReq && !retReq) |=> ($stable(curLevel) && !pcValid));

  assert_own_stack_R9: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> stateOut[0]);
endmodule

bind plvl_exc_ctrl plvl_chk #(.AW(AW), .YW(YW)) uChk (.*);

// File: tb/plvl_exc_ctrl_test.sv
module plvl_exc_ctrl_test;
  localparam int AW = 32;
  localparam int YW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excReq = 1'b0, retReq = 1'b0;
  logic [2:0] excKind = '0;
  logic [AW-1:0] curPc = '0;
  logic [7:0] curState = '0;
  logic [YW-1:0] syndIn = '0;
  logic irqToHyp = 1'b0, irqToMon = 1'b0, fiqToHyp = 1'b0, fiqToMon = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgLvl = '0, cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic pcValid;
  logic [AW-1:0] newPc, activeSp;
  logic [1:0] curLevel;
  logic [7:0] stateOut;
  logic [5+YW:0] syndOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  plvl_exc_ctrl #(.AW(AW), .YW(YW)) uut (.*);

  typedef struct packed {
    logic        isRet;
    logic [2:0]  kind;
    logic [31:0] pc;
    logic [7:0]  st;
    logic [15:0] synd;
    logic [3:0]  route;
    logic [1:0]  expLvl;
    logic [31:0] expPc;
    logic [7:0]  expSt;
    logic [5:0]  expCls;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 3'd0, 32'h100, 8'hF2, 16'h1234, 4'b0000, 2'd1, 32'h10400, 8'hF7, 6'h15},
    '{1'b1, 3'd0, 32'h0,   8'h00, 16'h0000, 4'b0000, 2'd0, 32'h104,   8'hF2, 6'h00},
    '{1'b0, 3'd1, 32'h200, 8'h00, 16'hAAAA, 4'b0000, 2'd1, 32'h10400, 8'h05, 6'h00},
    '{1'b0, 3'd1, 32'h300, 8'h30, 16'h0055, 4'b0000, 2'd2, 32'h20400, 8'h39, 6'h16},
    '{1'b0, 3'd4, 32'h400, 8'h00, 16'h0001, 4'b1000, 2'd2, 32'h20280, 8'h09, 6'h3A},
    '{1'b0, 3'd5, 32'h500, 8'h00, 16'h0002, 4'b0001, 2'd3, 32'h30500, 8'h0D, 6'h3B},
    '{1'b0, 3'd6, 32'h700, 8'h00, 16'h0003, 4'b0000, 2'd3, 32'h30380, 8'h0D, 6'h2F},
    '{1'b1, 3'd0, 32'h0,   8'h00, 16'h0000, 4'b0000, 2'd3, 32'h704,   8'h0D, 6'h00}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] lvl, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgLvl = lvl; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic step(input logic e, input logic r, input logic [2:0] k, input logic [31:0] pc,
                      input logic [7:0] st, input logic [15:0] sy, input logic [3:0] rt);
    @(negedge clk);
    excReq = e; retReq = r; excKind = k; curPc = pc; curState = st; syndIn = sy;
    {irqToHyp, irqToMon, fiqToHyp, fiqToMon} = rt;
    @(negedge clk);
    excReq = 1'b0; retReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 level", curLevel, 2'd3);
    check("R1 state", stateOut, 8'h0D);
    check("R1 pcValid", pcValid, 1'b0);
    check("R1 stack", activeSp, 0);
    check("R1 syndrome", syndOut, 0);

    for (int l = 0; l < 4; l++) begin
      cfg(l[1:0], 2'd0, 32'h10000 * l);
      cfg(l[1:0], 2'd1, 32'hA0 + l);
    end
    // R11 config writes leave the level alone
    check("R11 level after cfg", curLevel, 2'd3);
    check("R11 R9 own stack", activeSp, 32'hA3);

    cfg(2'd3, 2'd3, 32'h00);
    cfg(2'd3, 2'd2, 32'h5000);
    step(1'b0, 1'b1, 3'd0, 0, 0, 0, 0);
    check("R6 return pc", newPc, 32'h5000);
    check("R6 return valid", pcValid, 1'b1);
    check("R5 return level", curLevel, 2'd0);
    check("R9 level0 stack", activeSp, 32'hA0);
    @(negedge clk);
    check("R6 single pulse", pcValid, 1'b0);

    for (int i = 0; i < 8; i++) begin
      step(~TBL[i].isRet, TBL[i].isRet, TBL[i].kind, TBL[i].pc, TBL[i].st,
           TBL[i].synd, TBL[i].route);
      check($sformatf("R2 R4 level vec%0d", i), curLevel, TBL[i].expLvl);
      check($sformatf("R8 R6 pc vec%0d", i), newPc, TBL[i].expPc);
      check($sformatf("R5 state vec%0d", i), stateOut, TBL[i].expSt);
      if (!TBL[i].isRet)
        check($sformatf("R7 R3 syndrome vec%0d", i), syndOut,
              {TBL[i].expCls, (TBL[i].expCls == 6'h00) ? 16'h0 : TBL[i].synd});
    end

    // R10 return at level 0 ignored
    cfg(2'd3, 2'd3, 32'h00);
    cfg(2'd3, 2'd2, 32'h900);
    step(1'b0, 1'b1, 3'd0, 0, 0, 0, 0);
    check("R6 return to 0", newPc, 32'h900);
    step(1'b0, 1'b1, 3'd0, 0, 0, 0, 0);
    check("R10 no pc load", pcValid, 1'b0);
    check("R10 level kept", curLevel, 2'd0);
    check("R10 state kept", stateOut, 8'h00);

    // R3 monitor call from level 0
    step(1'b1, 1'b0, 3'd2, 32'h910, 8'h00, 16'hBEEF, 0);
    check("R3 level", curLevel, 2'd1);
    check("R3 pc", newPc, 32'h10400);
    check("R3 syndrome", syndOut, 0);

    // R9 return within level 1 onto the level-0 stack
    cfg(2'd1, 2'd3, 32'h04);
    cfg(2'd1, 2'd2, 32'hA00);
    step(1'b0, 1'b1, 3'd0, 0, 0, 0, 0);
    check("R5 same level state", stateOut, 8'h04);
    check("R9 shared stack", activeSp, 32'hA0);

    // R8 group 0x000 for a fault on the shared stack
    step(1'b1, 1'b0, 3'd3, 32'hA10, 8'h00, 16'h0777, 0);
    check("R8 group zero pc", newPc, 32'h10000);
    check("R4 fault level", curLevel, 2'd1);
    check("R9 own stack after entry", activeSp, 32'hA1);
    check("R7 fault syndrome", syndOut, {6'h20, 16'h0777});

    // R2 monitor call from level 1
    step(1'b1, 1'b0, 3'd2, 32'hB00, 8'h00, 16'h0009, 0);
    check("R2 monitor level", curLevel, 2'd3);
    check("R2 monitor pc", newPc, 32'h30400);

    // R10 exception wins over a simultaneous return
    step(1'b1, 1'b1, 3'd4, 32'hC00, 8'h00, 16'h0000, 0);
    check("R10 R4 irq kept at 3", curLevel, 2'd3);
    check("R10 exception pc", newPc, 32'h30280);

    // R2 supervisor call at level 3 stays at level 3
    step(1'b1, 1'b0, 3'd0, 32'hD00, 8'h00, 16'h0004, 0);
    check("R2 svc level", curLevel, 2'd3);
    check("R2 svc pc", newPc, 32'h30200);

    finishRun();
  end
endmodule